// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a supervisory timer that software must refresh at the right moment. A 7-bit counter runs down without stopping. Its clock comes from the bus clock through a fixed power-of-two divider and then a selectable extra divide by 1, 2, 4 or 8. Once software activates the watchdog, the block requests a system reset in two cases. The first is when the counter runs down past 0x40. The second is when software refreshes the counter too early, while its value is still above a programmed window. On the way down, the block raises an early-warning flag when the counter reaches 0x40. That flag can drive an interrupt, which gives software a last chance to refresh.

Software reaches the block through three 32-bit registers: a control word, a configuration word and a status word. The control word holds the counter and the activation bit. The configuration word holds the window, the early-warning enable and the divider select. The status word holds the early-warning flag. A write to the control word is a refresh: it loads the counter and restarts the divider.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control reads 0x0000007F (count 0x7F, inactive), configuration reads 0x0000007F (window 0x7F, interrupt enable 0, divider select 00), status reads 0, and both outputs are low.
- R2: Without a refresh, the count falls by one every 2^(BASE_LOG2 + SEL) clock cycles, where SEL is configuration bits [12:11]. It wraps from 0x00 to 0x7F. Every control write reloads the count and restarts the divider, so the next step comes a full period after that write.
- R3: While the watchdog is active, the step from 0x40 to 0x3F requests a reset. While it is inactive, the same step requests nothing.
- R4: Writing 1 to control bit 7 activates the watchdog. Only block reset deactivates it; a later write of 0 to bit 7 has no effect.
- R5: A control write made while the watchdog is active, or by the write that activates it, requests a reset if the count before the write is above the window. The window is configuration bits [6:0].
- R6: A control write that leaves the watchdog active and carries 0 in bit 6 requests a reset.
- R7: Status bit 0 is set when the count steps down to 0x40, whether or not the interrupt is enabled. Writing 0 to it clears it; writing 1 leaves it unchanged.
- R8: The interrupt output equals status bit 0 ANDed with the interrupt enable, configuration bit 9. Writing 1 to that bit sets the enable; only block reset clears it.
- R9: Each reset request appears on the reset output as a pulse one clock cycle long, one cycle after its cause.
- R10: Register select (word index) 0 is control (byte offset 0x0), 1 is configuration (0x4) and 2 is status (0x8). Control reads {activation, count[6:0]}. Configuration reads divider select at [12:11], enable at [9] and window at [6:0]. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low block reset |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_word | input | 2 | Register select (byte offset divided by 4) |
| bus_wdata | input | 13 | Write data, the bits 12:0 that are writable |
| bus_rdata | output | 32 | Read data of the selected word |
| wdt_reset | output | 1 | One-cycle reset request |
| wdt_irq | output | 1 | Early-warning interrupt |

## Verification
The hardest state to reach is a refresh that lands just inside the window. The counter must first run down by several dozen steps from 0x7F while the watchdog is already active, and any mistake on the way fires a reset. The bench shortens the fixed divider through a parameter. It then opens a window at 0x50 and activates with a refresh that is too early on purpose, which shows the early-refresh reset. After that it waits exactly the number of periods that brings the count to the window value and refreshes again, and this time expects no pulse.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  localparam int CNT_W   = 7;
  localparam int WDATA_W = 13;
  localparam int SEL_W   = 2;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Last prescaler count before a tick: period minus one.
  function automatic logic [31:0] tick_limit(int base_log2, logic [SEL_W-1:0] sel);
    return (32'd1 << (base_log2 + int'(sel))) - 32'd1;
  endfunction

  // Early-refresh rule: a refresh above the window is a violation.
  function automatic logic above_window(logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction
endpackage

// File: rtl/wdw_prescaler.sv
module wdw_prescaler
  import wdw_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = BASE_LOG2 + 3;

  logic [PW-1:0] cnt_q;
  logic [31:0]   lim;

  assign lim  = tick_limit(BASE_LOG2, sel);
  assign tick = !restart && ({{(32-PW){1'b0}}, cnt_q} >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart||tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R2
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_act,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             act,
  output logic             hit_40,
  output logic             req
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, req_q;
  logic             act_next, dec, timeout, early, low_write, req_d;

  assign act_next  = act_q | (ctrl_wr & wr_act);
  assign dec       = tick & !ctrl_wr;
  assign timeout   = dec & act_q & (cnt_q == 7'h40);
  assign early     = ctrl_wr & act_next & above_window(cnt_q, win);
  assign low_write = ctrl_wr & act_next & !wr_cnt[CNT_W-1];
  assign req_d     = timeout | early | low_write;
  assign hit_40    = dec & (cnt_q == 7'h41);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 7'h7F;
      act_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      act_q <= act_next;
      req_q <= req_d & !req_q;
      if (ctrl_wr)  cnt_q <= wr_cnt;
      else if (dec) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign act = act_q;
  assign req = req_q;

  AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q); // R4
  AST_TIMEOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && act_q && cnt_q == 7'h40) |=> req_q); // R3
  AST_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (act_q || wr_act) && cnt_q > win && !req_q) |=> req_q); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr) |=> cnt_q == $past(cnt_q) - 7'd1); // R2
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R9
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdw_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_word,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               wdt_reset,
  output logic               wdt_irq
);
  reg_sel_e         sel;
  logic             ctrl_wr, cfg_wr, stat_wr;
  logic [CNT_W-1:0] win_q, cnt;
  logic [SEL_W-1:0] div_q;
  logic             ewi_q, flag_q, act, hit_40, tick;

  assign sel     = reg_sel_e'(bus_word);
  assign ctrl_wr = bus_wr && sel == REG_CTRL;
  assign cfg_wr  = bus_wr && sel == REG_CFG;
  assign stat_wr = bus_wr && sel == REG_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 7'h7F;
      div_q  <= '0;
      ewi_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        win_q <= bus_wdata[6:0];
        div_q <= bus_wdata[12:11];
        ewi_q <= ewi_q | bus_wdata[9];
      end
      if (hit_40)                       flag_q <= 1'b1;
      else if (stat_wr && !bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  wdw_prescaler #(.BASE_LOG2(BASE_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .sel(div_q), .tick(tick)
  );

  wdw_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .wr_cnt(bus_wdata[6:0]), .wr_act(bus_wdata[7]), .win(win_q),
    .cnt(cnt), .act(act), .hit_40(hit_40), .req(wdt_reset)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = {24'd0, act, cnt};
      REG_CFG:  bus_rdata = {19'd0, div_q, 1'b0, ewi_q, 2'b00, win_q};
      REG_STAT: bus_rdata = {31'd0, flag_q};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign wdt_irq = flag_q & ewi_q;

  AST_FLAG_AT_40: assert property (@(posedge clk) disable iff (!rst_n)
    hit_40 |=> flag_q); // R7
  AST_EWI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ewi_q |=> ewi_q); // R8
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(stat_wr && !bus_wdata[0])) |=> flag_q); // R7
endmodule

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;
  localparam int B = 4;
  localparam int P0 = 1 << B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word = 2'd0;
  logic [12:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset, wdt_irq;

  int n_chk = 0, n_fail = 0, pulses = 0, long_pulses = 0;
  logic prev_rst = 1'b0;

  always #4 clk = ~clk;

  win_watchdog #(.BASE_LOG2(B)) u_win_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_reset(wdt_reset), .wdt_irq(wdt_irq)
  );

  always @(negedge clk) begin
    if (wdt_reset) pulses++;
    if (wdt_reset && prev_rst) long_pulses++;
    prev_rst = wdt_reset;
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] w, logic [12:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] w, output logic [31:0] v);
    bus_word = w; #1; v = bus_rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    rd(2'd0, v); check("R1 ctrl", v, 32'h7F);
    rd(2'd1, v); check("R1 cfg", v, 32'h7F);
    rd(2'd2, v); check("R1 stat", v, 32'h0);
    check("R1 reset out", {31'd0, wdt_reset}, 0);
    check("R1 irq out", {31'd0, wdt_irq}, 0);
    rd(2'd3, v); check("R10 unused word", v, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    int p0;
    p0 = pulses;
    wr(2'd0, 13'h050); waitn(P0*3 + P0/2);
    rd(2'd0, v); check("R2 three steps div1", v, 32'h4D);
    wr(2'd0, 13'h050); waitn(P0/2 + 2);
    wr(2'd0, 13'h050); waitn(P0/2 + 2);
    rd(2'd0, v); check("R2 restart on write", v, 32'h50);
    wr(2'd1, 13'h107F);
    rd(2'd1, v); check("R10 cfg layout", v, 32'h107F);
    wr(2'd0, 13'h050); waitn(P0*4*2 + P0*2);
    rd(2'd0, v); check("R2 two steps div4", v, 32'h4E);
    wr(2'd1, 13'h007F);
    wr(2'd0, 13'h001); waitn(P0*2 + P0/2);
    rd(2'd0, v); check("R2 wrap to 7F", v, 32'h7F);
    check("R3 no reset when inactive", pulses - p0, 0);
  endtask

  task automatic t_flag();
    logic [31:0] v;
    int p0;
    p0 = pulses;
    wr(2'd0, 13'h042); waitn(P0*2 + P0/2);
    rd(2'd0, v); check("R2 count at 40", v, 32'h40);
    rd(2'd2, v); check("R7 flag set without enable", v, 1);
    check("R8 irq masked", {31'd0, wdt_irq}, 0);
    check("R3 inactive crossing", pulses - p0, 0);
    wr(2'd1, 13'h027F);
    check("R8 irq on enable", {31'd0, wdt_irq}, 1);
    wr(2'd1, 13'h007F);
    rd(2'd1, v); check("R8 enable sticky", v, 32'h27F);
    wr(2'd2, 13'h001);
    rd(2'd2, v); check("R7 write 1 keeps flag", v, 1);
    wr(2'd2, 13'h000);
    rd(2'd2, v); check("R7 write 0 clears", v, 0);
    check("R8 irq follows flag", {31'd0, wdt_irq}, 0);
  endtask

  task automatic t_activation();
    logic [31:0] v;
    int p0;
    do_reset();
    p0 = pulses;
    wr(2'd0, 13'h0FF);
    rd(2'd0, v); check("R4 activated", v, 32'hFF);
    wr(2'd0, 13'h07F);
    rd(2'd0, v); check("R4 write 0 ignored", v, 32'hFF);
    check("R5 in-window refresh quiet", pulses - p0, 0);
    wr(2'd0, 13'h0BF); waitn(2);
    check("R6 bit6 low write resets", pulses - p0, 1);
    check("R9 single cycle", long_pulses, 0);
  endtask

  task automatic t_timeout();
    int p0;
    do_reset();
    p0 = pulses;
    wr(2'd0, 13'h0C2); waitn(P0*2 + P0/2);
    check("R3 no reset at 40", pulses - p0, 0);
    waitn(P0);
    check("R3 reset on 40 to 3F", pulses - p0, 1);
    check("R9 single cycle timeout", long_pulses, 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    int p0;
    do_reset();
    wr(2'd1, 13'h050);
    p0 = pulses;
    wr(2'd0, 13'h0FF); waitn(2);
    check("R5 early refresh resets", pulses - p0, 1);
    waitn(P0*47 + P0/2 - 2);
    rd(2'd0, v); check("R2 count at window", v, 32'hD0);
    p0 = pulses;
    wr(2'd0, 13'h0FF); waitn(2);
    check("R5 refresh at window quiet", pulses - p0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_prescale();
        t_flag();
        t_activation();
        t_timeout();
        t_window();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule